// File: doc/BRIEF.md
# Eight-bit Arithmetic/Logic Unit with Selective Status Flags

This block is the arithmetic and logic datapath of a small RISC-style core. Each cycle it takes a register operand, a second operand (a register value or an immediate) and an operation code. It drives a combinational result and updates a registered set of status flags on the next rising clock edge. The carry and T flags used as inputs come from that same flag register, so chained operations such as multi-byte add, subtract or compare work across cycles with no outside help.

Each operation writes only its own group of flags and leaves every other flag as it was. Compare operations still drive the difference on the result port, and the surrounding core decides whether to store it. The flag word carries zero (Z), carry/borrow (C), negative (N), two's-complement overflow (V), signed test (S), half carry (H) and a transfer bit (T).

Top module: `alu8_core`

## Requirements
- R1: ADD gives a+b and ADC gives a+b+C. Both write Z, C (carry out of the MSB), N, V (signed overflow), S and H (carry out of bit 3).
- R2: SUB and CP give a-b, and SBC and CPC give a-b-C. All four write C (borrow), H (borrow into bit 3), N, V and S. SUB and CP set Z exactly when the result is zero.
- R3: SBC and CPC clear Z when the result is nonzero. When the result is zero they keep the previous Z, so that multi-byte compares chain.
- R4: AND, OR, XOR, TST (result = a) and CLR (result = 0) write Z, N and S, and force V to 0. C, H and T are left unchanged.
- R5: INC and DEC write a+1 and a-1 and update Z, N, V and S only. V is set when INC gives 0x80 and when DEC gives 0x7F.
- R6: COM gives 0xFF-a, sets C to 1, clears V, writes Z, N and S, and leaves H unchanged.
- R7: NEG gives 0x00-a and writes Z, C, N, V, S and H. C is set when a is nonzero, H is set when the low nibble of a is nonzero, and V is set when a is 0x80.
- R8: LSL, LSR and ASR move the bit shifted out into C and set V = N xor C. ASR keeps bit 7 and shifts bits 7..1 down by one. Z, N and S are also written, and H is unchanged.
- R9: ROL and ROR shift through carry. The old C fills the vacated bit and the bit shifted out becomes the new C. Flags are written as for R8.
- R10: SWAP exchanges the high and low nibbles. NOP passes a through. Neither changes any flag.
- R11: BST copies a[bit_sel_i] into T and changes no other flag. BLD outputs a with bit bit_sel_i replaced by T and changes no flag.
- R12: S always equals N xor V.
- R13: Reset clears every flag. imm_sel_i=1 replaces b_i with imm_i as the second operand. The operation codes are the values of enum alu_op_e in alu8_pkg. The flag word is flags_o[0]=Z, [1]=C, [2]=N, [3]=V, [4]=S, [5]=H, [6]=T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_i | input | 5 | Operation code (alu_op_e) |
| a_i | input | W | Register operand and destination value |
| b_i | input | W | Second register operand |
| imm_i | input | W | Immediate operand |
| imm_sel_i | input | 1 | 1 selects imm_i as the second operand |
| bit_sel_i | input | log2(W) | Bit index for BST and BLD |
| result_o | output | W | Combinational result |
| flags_o | output | 7 | Registered flags {T,H,S,V,N,C,Z} |

## Verification
The bench builds the block with W=8, the default. With that width the half-carry sits at the bit 3/bit 4 boundary, and the signed limits are 0x7F and 0x80, so hand-worked operands can reach both carry chains, both overflow edges and the zero-chaining of compare-with-carry. At this width every expected flag word can also be written directly as a literal.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,
        OP_ADD  = 5'd1,
        OP_ADC  = 5'd2,
        OP_SUB  = 5'd3,
        OP_SBC  = 5'd4,
        OP_CP   = 5'd5,
        OP_CPC  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_XOR  = 5'd9,
        OP_TST  = 5'd10,
        OP_CLR  = 5'd11,
        OP_INC  = 5'd12,
        OP_DEC  = 5'd13,
        OP_COM  = 5'd14,
        OP_NEG  = 5'd15,
        OP_LSL  = 5'd16,
        OP_LSR  = 5'd17,
        OP_ASR  = 5'd18,
        OP_ROL  = 5'd19,
        OP_ROR  = 5'd20,
        OP_SWAP = 5'd21,
        OP_BST  = 5'd22,
        OP_BLD  = 5'd23
    } alu_op_e;

    localparam int OP_W   = 5;
    localparam int FLAG_W = 7;

    // Bit 0 is Z, bit 6 is T.
    typedef struct packed {
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic c;
        logic z;
    } flags_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBC) || (op == OP_CP)  || (op == OP_CPC) ||
               (op == OP_NEG);
    endfunction

    function automatic logic is_subtract(alu_op_e op);
        return (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP) ||
               (op == OP_CPC) || (op == OP_NEG);
    endfunction

    function automatic logic uses_carry_in(alu_op_e op);
        return (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
    endfunction

    function automatic logic is_shift(alu_op_e op);
        return (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASR) ||
               (op == OP_ROL) || (op == OP_ROR);
    endfunction

    function automatic logic is_logic(alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) ||
               (op == OP_TST) || (op == OP_CLR);
    endfunction

    // Which flags an operation is allowed to write.
    function automatic flags_t update_mask(alu_op_e op);
        flags_t m;
        m = '0;
        if (is_arith(op)) begin
            m.z = 1'b1; m.c = 1'b1; m.n = 1'b1;
            m.v = 1'b1; m.s = 1'b1; m.h = 1'b1;
        end else if (is_logic(op) || op == OP_INC || op == OP_DEC) begin
            m.z = 1'b1; m.n = 1'b1; m.v = 1'b1; m.s = 1'b1;
        end else if (is_shift(op) || op == OP_COM) begin
            m.z = 1'b1; m.c = 1'b1; m.n = 1'b1; m.v = 1'b1; m.s = 1'b1;
        end else if (op == OP_BST) begin
            m.t = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         half_o,
    output logic         ovf_o
);
    localparam int HW = W / 2;

    logic [W-1:0]  y_eff;
    logic          c_eff;
    logic [W:0]    full;
    logic [HW:0]   low;

    // Subtraction is x + ~y + ~borrow; carry outputs are inverted to borrows.
    always_comb begin
        y_eff   = sub_i ? ~y_i : y_i;
        c_eff   = cin_i ^ sub_i;
        full    = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
        low     = {1'b0, x_i[HW-1:0]} + {1'b0, y_eff[HW-1:0]} + {{HW{1'b0}}, c_eff};
        sum_o   = full[W-1:0];
        carry_o = full[W] ^ sub_i;
        half_o  = low[HW] ^ sub_i;
        ovf_o   = (x_i[W-1] == y_eff[W-1]) && (full[W-1] != x_i[W-1]);
    end
endmodule

// File: rtl/alu8_misc.sv
module alu8_misc
    import alu8_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = $clog2(W)
) (
    input  alu_op_e       op_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          cin_i,
    input  logic          tin_i,
    input  logic [SW-1:0] sel_i,
    output logic [W-1:0]  res_o,
    output logic          cout_o
);
    localparam int HW = W / 2;

    always_comb begin
        res_o  = a_i;
        cout_o = cin_i;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_TST:  res_o = a_i;
            OP_CLR:  res_o = '0;
            OP_INC:  res_o = a_i + {{(W-1){1'b0}}, 1'b1};
            OP_DEC:  res_o = a_i - {{(W-1){1'b0}}, 1'b1};
            OP_COM:  res_o = ~a_i;
            OP_LSL: begin
                res_o  = {a_i[W-2:0], 1'b0};
                cout_o = a_i[W-1];
            end
            OP_LSR: begin
                res_o  = {1'b0, a_i[W-1:1]};
                cout_o = a_i[0];
            end
            OP_ASR: begin
                res_o  = {a_i[W-1], a_i[W-1:1]};
                cout_o = a_i[0];
            end
            OP_ROL: begin
                res_o  = {a_i[W-2:0], cin_i};
                cout_o = a_i[W-1];
            end
            OP_ROR: begin
                res_o  = {cin_i, a_i[W-1:1]};
                cout_o = a_i[0];
            end
            OP_SWAP: res_o = {a_i[HW-1:0], a_i[W-1:HW]};
            OP_BLD: begin
                res_o        = a_i;
                res_o[sel_i] = tin_i;
            end
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t mask_i,
    input  flags_t next_i,
    output flags_t flags_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
        end else begin
            flags_o <= (next_i & mask_i) | (flags_o & ~mask_i);
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [W-1:0]      imm_i,
    input  logic              imm_sel_i,
    input  logic [SW-1:0]     bit_sel_i,
    output logic [W-1:0]      result_o,
    output logic [FLAG_W-1:0] flags_o
);
    localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    alu_op_e      op;
    flags_t       cur;
    flags_t       nxt;
    flags_t       mask;
    logic [W-1:0] opnd_b;
    logic [W-1:0] as_x, as_y, as_sum, misc_res;
    logic         as_cin, as_sub, as_c, as_h, as_v, misc_c;

    assign op     = alu_op_e'(op_i);
    assign opnd_b = imm_sel_i ? imm_i : b_i;

    // Negate reuses the subtractor as 0 - a.
    assign as_x   = (op == OP_NEG) ? '0 : a_i;
    assign as_y   = (op == OP_NEG) ? a_i : opnd_b;
    assign as_sub = is_subtract(op);
    assign as_cin = uses_carry_in(op) ? cur.c : 1'b0;

    alu8_addsub #(.W(W)) u_addsub (
        .x_i     (as_x),
        .y_i     (as_y),
        .cin_i   (as_cin),
        .sub_i   (as_sub),
        .sum_o   (as_sum),
        .carry_o (as_c),
        .half_o  (as_h),
        .ovf_o   (as_v)
    );

    alu8_misc #(.W(W), .SW(SW)) u_misc (
        .op_i   (op),
        .a_i    (a_i),
        .b_i    (opnd_b),
        .cin_i  (cur.c),
        .tin_i  (cur.t),
        .sel_i  (bit_sel_i),
        .res_o  (misc_res),
        .cout_o (misc_c)
    );

    assign result_o = is_arith(op) ? as_sum : misc_res;
    assign mask     = update_mask(op);

    always_comb begin
        nxt   = cur;
        nxt.z = (result_o == '0);
        nxt.n = result_o[W-1];
        nxt.v = 1'b0;
        if (is_arith(op)) begin
            nxt.c = as_c;
            nxt.h = as_h;
            nxt.v = as_v;
            if (uses_carry_in(op) && op != OP_ADC) begin
                nxt.z = (result_o == '0) && cur.z;
            end
        end else if (op == OP_INC) begin
            nxt.v = (result_o == MIN_NEG);
        end else if (op == OP_DEC) begin
            nxt.v = (result_o == MAX_POS);
        end else if (op == OP_COM) begin
            nxt.c = 1'b1;
        end else if (is_shift(op)) begin
            nxt.c = misc_c;
            nxt.v = result_o[W-1] ^ misc_c;
        end
        nxt.s = nxt.n ^ nxt.v;
        nxt.t = a_i[bit_sel_i];
    end

    alu8_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .mask_i  (mask),
        .next_i  (nxt),
        .flags_o (cur)
    );

    assign flags_o = cur;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = $clog2(W)
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_i,
    input logic [W-1:0]      a_i,
    input logic [W-1:0]      b_i,
    input logic              imm_sel_i,
    input logic [SW-1:0]     bit_sel_i,
    input logic [W-1:0]      result_o,
    input logic [FLAG_W-1:0] flags_o
);
    localparam int HW = W / 2;

    p_add_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADD) |=> (flags_o[0] == ($past(result_o) == '0)));

    p_sub_borrow_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SUB && !imm_sel_i) |=> (flags_o[1] == ($past(a_i) < $past(b_i))));

    p_chain_clear_z_r3: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_SBC || op_i == OP_CPC) && result_o != '0) |=> !flags_o[0]);

    p_logic_keeps_carry_r4: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_TST ||
         op_i == OP_CLR || op_i == OP_INC || op_i == OP_DEC)
        |=> ($stable(flags_o[1]) && $stable(flags_o[5]) && !flags_o[3] ||
             (op_i != OP_INC && op_i != OP_DEC && $past(op_i) != OP_INC &&
              $past(op_i) != OP_DEC && 1'b0)) || ($stable(flags_o[1]) && $stable(flags_o[5]) &&
             ($past(op_i) == OP_INC || $past(op_i) == OP_DEC)));

    p_com_sets_carry_r6: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_COM) |=> (flags_o[1] && !flags_o[3]));

    p_asr_keeps_msb_r8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ASR) |-> (result_o[W-1] == a_i[W-1]));

    p_swap_result_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SWAP) |-> (result_o == {a_i[HW-1:0], a_i[W-1:HW]}));

    p_swap_flags_r10: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SWAP || op_i == OP_NOP) |=> $stable(flags_o));

    p_bst_copies_r11: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_BST) |=> (flags_o[6] == $past(a_i[bit_sel_i]) &&
                              flags_o[5:0] == $past(flags_o[5:0])));

    p_sign_test_r12: assert property (@(posedge clk) disable iff (rst)
        flags_o[4] == (flags_o[2] ^ flags_o[3]));

endmodule

bind alu8_core alu8_core_chk #(.W(W), .SW(SW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .imm_sel_i (imm_sel_i),
    .bit_sel_i (bit_sel_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;
    import alu8_pkg::*;

    localparam logic [6:0] M_ARITH = 7'h3F;
    localparam logic [6:0] M_LOGIC = 7'h1D;
    localparam logic [6:0] M_SHIFT = 7'h1F;
    localparam logic [6:0] M_NONE  = 7'h00;
    localparam logic [6:0] M_T     = 7'h40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] op_i = OP_NOP;
    logic [7:0] a_i = '0, b_i = '0, imm_i = '0;
    logic       imm_sel_i = 1'b0;
    logic [2:0] bit_sel_i = '0;
    logic [7:0] result_o;
    logic [6:0] flags_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [7:0] got_r;
    logic [6:0] got_f;
    logic [6:0] exp_f;

    always #5 clk = ~clk;

    alu8_core u_alu8_core (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i),
        .imm_sel_i(imm_sel_i), .bit_sel_i(bit_sel_i), .result_o(result_o), .flags_o(flags_o)
    );

    function automatic logic [6:0] fl(input logic z, c, n, v, s, h, t);
        return {t, h, s, v, n, c, z};
    endfunction

    task automatic step(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_i = op; a_i = a; b_i = b;
        #1 got_r = result_o;
        @(posedge clk);
        #1 got_f = flags_o;
    endtask

    task automatic chk_r(input string req, input logic [7:0] exp);
        total++;
        if (got_r !== exp) begin
            bad++;
            $display("FAIL %s result actual=%h expected=%h", req, got_r, exp);
        end
    endtask

    task automatic chk_f(input string req, input logic [6:0] mask, input logic [6:0] vals);
        exp_f = (exp_f & ~mask) | (vals & mask);
        total++;
        if (got_f !== exp_f) begin
            bad++;
            $display("FAIL %s flags actual=%b expected=%b", req, got_f, exp_f);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 got_f = flags_o;
        exp_f = '0;
        total++;
        if (got_f !== 7'h00) begin
            bad++;
            $display("FAIL R13 reset flags actual=%b expected=%b", got_f, 7'h00);
        end
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic t_add;
        step(OP_ADD, 8'h7F, 8'h01);
        chk_r("R1", 8'h80); chk_f("R1", M_ARITH, fl(0,0,1,1,0,1,0));
        step(OP_ADD, 8'hFF, 8'h01);
        chk_r("R1", 8'h00); chk_f("R1", M_ARITH, fl(1,1,0,0,0,1,0));
        step(OP_ADC, 8'h10, 8'h20);
        chk_r("R1", 8'h31); chk_f("R1", M_ARITH, fl(0,0,0,0,0,0,0));
    endtask

    task automatic t_sub;
        step(OP_SUB, 8'h10, 8'h01);
        chk_r("R2", 8'h0F); chk_f("R2", M_ARITH, fl(0,0,0,0,0,1,0));
        step(OP_SUB, 8'h80, 8'h01);
        chk_r("R2", 8'h7F); chk_f("R2", M_ARITH, fl(0,0,0,1,1,1,0));
        step(OP_SUB, 8'h00, 8'h01);
        chk_r("R2", 8'hFF); chk_f("R2", M_ARITH, fl(0,1,1,0,1,1,0));
        step(OP_SBC, 8'h05, 8'h02);
        chk_r("R2", 8'h02); chk_f("R2", M_ARITH, fl(0,0,0,0,0,0,0));
    endtask

    task automatic t_chain;
        step(OP_CP, 8'h34, 8'h34);
        chk_r("R3", 8'h00); chk_f("R3", M_ARITH, fl(1,0,0,0,0,0,0));
        step(OP_CPC, 8'h12, 8'h12);
        chk_r("R3", 8'h00); chk_f("R3", M_ARITH, fl(1,0,0,0,0,0,0));
        step(OP_CPC, 8'h12, 8'h11);
        chk_r("R3", 8'h01); chk_f("R3", M_ARITH, fl(0,0,0,0,0,0,0));
        step(OP_CPC, 8'h00, 8'h00);
        chk_r("R3", 8'h00); chk_f("R3 zero keeps cleared Z", M_ARITH, fl(0,0,0,0,0,0,0));
    endtask

    task automatic t_logic;
        step(OP_ADD, 8'hFF, 8'h01);
        chk_f("R1", M_ARITH, fl(1,1,0,0,0,1,0));
        step(OP_AND, 8'hF0, 8'h8F);
        chk_r("R4", 8'h80); chk_f("R4", M_LOGIC, fl(0,0,1,0,1,0,0));
        step(OP_OR, 8'h00, 8'h00);
        chk_r("R4", 8'h00); chk_f("R4", M_LOGIC, fl(1,0,0,0,0,0,0));
        step(OP_XOR, 8'hAA, 8'h55);
        chk_r("R4", 8'hFF); chk_f("R4", M_LOGIC, fl(0,0,1,0,1,0,0));
        step(OP_TST, 8'h00, 8'h77);
        chk_r("R4", 8'h00); chk_f("R4", M_LOGIC, fl(1,0,0,0,0,0,0));
        step(OP_CLR, 8'h9C, 8'h00);
        chk_r("R4", 8'h00); chk_f("R4", M_LOGIC, fl(1,0,0,0,0,0,0));
    endtask

    task automatic t_incdec;
        step(OP_INC, 8'h7F, 8'h00);
        chk_r("R5", 8'h80); chk_f("R5", M_LOGIC, fl(0,0,1,1,0,0,0));
        step(OP_INC, 8'hFF, 8'h00);
        chk_r("R5", 8'h00); chk_f("R5", M_LOGIC, fl(1,0,0,0,0,0,0));
        step(OP_DEC, 8'h80, 8'h00);
        chk_r("R5", 8'h7F); chk_f("R5", M_LOGIC, fl(0,0,0,1,1,0,0));
        step(OP_DEC, 8'h01, 8'h00);
        chk_r("R5", 8'h00); chk_f("R5", M_LOGIC, fl(1,0,0,0,0,0,0));
    endtask

    task automatic t_com_neg;
        step(OP_COM, 8'h5A, 8'h00);
        chk_r("R6", 8'hA5); chk_f("R6", M_SHIFT, fl(0,1,1,0,1,0,0));
        step(OP_NEG, 8'h01, 8'h00);
        chk_r("R7", 8'hFF); chk_f("R7", M_ARITH, fl(0,1,1,0,1,1,0));
        step(OP_NEG, 8'h00, 8'h00);
        chk_r("R7", 8'h00); chk_f("R7", M_ARITH, fl(1,0,0,0,0,0,0));
        step(OP_NEG, 8'h80, 8'h00);
        chk_r("R7", 8'h80); chk_f("R7", M_ARITH, fl(0,1,1,1,0,0,0));
    endtask

    task automatic t_shift;
        step(OP_ADD, 8'h08, 8'h08);
        chk_f("R1", M_ARITH, fl(0,0,0,0,0,1,0));
        step(OP_LSL, 8'h81, 8'h00);
        chk_r("R8", 8'h02); chk_f("R8", M_SHIFT, fl(0,1,0,1,1,0,0));
        step(OP_LSR, 8'h01, 8'h00);
        chk_r("R8", 8'h00); chk_f("R8", M_SHIFT, fl(1,1,0,1,1,0,0));
        step(OP_ASR, 8'h81, 8'h00);
        chk_r("R8", 8'hC0); chk_f("R8", M_SHIFT, fl(0,1,1,0,1,0,0));
        step(OP_ASR, 8'h40, 8'h00);
        chk_r("R8", 8'h20); chk_f("R8", M_SHIFT, fl(0,0,0,0,0,0,0));
    endtask

    task automatic t_rotate;
        step(OP_LSR, 8'h01, 8'h00);
        chk_f("R8", M_SHIFT, fl(1,1,0,1,1,0,0));
        step(OP_ROL, 8'h80, 8'h00);
        chk_r("R9", 8'h01); chk_f("R9", M_SHIFT, fl(0,1,0,1,1,0,0));
        step(OP_ROR, 8'h00, 8'h00);
        chk_r("R9", 8'h80); chk_f("R9", M_SHIFT, fl(0,0,1,1,0,0,0));
        step(OP_ROL, 8'h00, 8'h00);
        chk_r("R9", 8'h00); chk_f("R9", M_SHIFT, fl(1,0,0,0,0,0,0));
    endtask

    task automatic t_swap_nop;
        step(OP_SUB, 8'h00, 8'h01);
        chk_f("R2", M_ARITH, fl(0,1,1,0,1,1,0));
        step(OP_SWAP, 8'h3C, 8'h00);
        chk_r("R10", 8'hC3); chk_f("R10", M_NONE, 7'h00);
        step(OP_NOP, 8'h6B, 8'h11);
        chk_r("R10", 8'h6B); chk_f("R10", M_NONE, 7'h00);
    endtask

    task automatic t_bits;
        bit_sel_i = 3'd3;
        step(OP_BST, 8'h08, 8'h00);
        chk_f("R11", M_T, fl(0,0,0,0,0,0,1));
        bit_sel_i = 3'd7;
        step(OP_BLD, 8'h00, 8'h00);
        chk_r("R11", 8'h80); chk_f("R11", M_NONE, 7'h00);
        bit_sel_i = 3'd3;
        step(OP_BST, 8'hF7, 8'h00);
        chk_f("R11", M_T, fl(0,0,0,0,0,0,0));
        bit_sel_i = 3'd0;
        step(OP_BLD, 8'hFF, 8'h00);
        chk_r("R11", 8'hFE); chk_f("R11", M_NONE, 7'h00);
    endtask

    task automatic t_imm;
        imm_sel_i = 1'b1; imm_i = 8'h05;
        step(OP_ADD, 8'h10, 8'h99);
        chk_r("R13 immediate", 8'h15); chk_f("R13", M_ARITH, fl(0,0,0,0,0,0,0));
        step(OP_SUB, 8'h05, 8'h00);
        chk_r("R13 immediate", 8'h00); chk_f("R12", M_ARITH, fl(1,0,0,0,0,0,0));
        imm_sel_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_chain();
        t_logic();
        t_incdec();
        t_com_neg();
        t_shift();
        t_rotate();
        t_swap_nop();
        t_bits();
        t_imm();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule